// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block resolves the control-transfer instructions of an 8-bit processor with a 16-bit address space. Each cycle, a fetch stage can present the first opcode byte, a flag showing that the byte follows the 0xED prefix, and the two immediate bytes. It also presents the flag register, the B register, the address of the instruction's first byte and the word at the top of the stack. The block classifies the instruction and tests its condition code. One clock later it returns the next PC, whether the branch was taken, any stack push or pop, the new B value, an interrupt-enable copy strobe and the instruction's cost in T-states.

A two-state machine controls the output stage. `ST_IDLE` means no result is held. `ST_HOLD` means a result registered on the last edge is on the outputs. The transition `ST_IDLE -> ST_HOLD` and the self-loop `ST_HOLD -> ST_HOLD` both occur when `dec_en` is high at a clock edge. The transitions `ST_HOLD -> ST_IDLE` and `ST_IDLE -> ST_IDLE` both occur when `dec_en` is low. Reset forces `ST_IDLE`.

Top module: `cf_nextpc_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid` and every result output are 0 until the first accepted instruction.
- R2: An instruction sampled with `dec_en` high at a clock edge appears on the outputs with `res_valid` = 1 right after that edge. An edge with `dec_en` low drives `res_valid` and all result outputs to 0.
- R3: Conditional JP (11ccc010), CALL (11ccc100) and RET (11ccc000) test code ccc from opcode bits 5:3. The codes are 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 P/V clear, 5 P/V set, 6 S clear and 7 S set. The flag bits are S = 7, Z = 6, P/V = 2 and C = 0.
- R4: Conditional JR (001cc000) tests only the codes 0 to 3 of R3, taken from opcode bits 4:3.
- R5: JP (0xC3) always goes to {imm_hi, imm_lo}. Conditional JP goes there when the condition holds and to pc+3 otherwise.
- R6: JR (0x18), and conditional JR when its condition holds, go to pc + 2 + the sign-extended imm_lo, modulo 2^16. A conditional JR that is not taken goes to pc+2.
- R7: DJNZ (0x10) outputs `b_next` = B-1 modulo 256. It takes the relative branch of R6 only if B-1 is nonzero, and goes to pc+2 otherwise. B = 0 wraps to 0xFF and branches. Every other instruction outputs `b_next` = B.
- R8: CALL (0xCD), and conditional CALL when taken, raise `push_req` with `ret_addr` = pc+3 and jump to {imm_hi, imm_lo}. A conditional CALL that is not taken pushes nothing and goes to pc+3.
- R9: RET (0xC9), and conditional RET when taken, raise `pop_req` and load `stack_word`. A conditional RET that is not taken pops nothing and goes to pc+1.
- R10: RST (11ttt111) pushes `ret_addr` = pc+1 and jumps to 0x0000 + ttt*8.
- R11: With `prefix_ed` = 1, opcode 0x4D (return from interrupt) and 0x45 (return from non-maskable interrupt) both pop and load `stack_word`. Only 0x45 raises `iff_copy`.
- R12: `cycles` is 4 for NOP and 10 for JP (taken or not). JR is 12, and conditional JR is 12 taken or 7 not taken. DJNZ is 13 taken or 8 not taken. CALL is 17, and conditional CALL is 17 taken or 10 not taken. RET is 10, and conditional RET is 11 taken or 5 not taken. RST is 11, and both prefixed returns are 14.
- R13: Any other byte, or any prefixed byte other than 0x45 and 0x4D, sets `unsupported`. The block then goes to pc+1 with `taken` = 0, no push or pop, and `cycles` = 4.
- R14: NOP (0x00) goes to pc+1 with `taken` = 0 and no push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Accept the presented instruction this edge |
| prefix_ed | input | 1 | The opcode byte follows the 0xED prefix |
| opcode | input | 8 | Opcode byte |
| imm_lo | input | 8 | First immediate byte (low byte or relative offset) |
| imm_hi | input | 8 | Second immediate byte (high byte) |
| flags | input | 8 | Flag register |
| reg_b | input | 8 | Current B register |
| pc_cur | input | 16 | Address of the instruction's first byte |
| stack_word | input | 16 | Word at the top of the stack |
| res_valid | output | 1 | A result is held on the outputs |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Control was transferred |
| push_req | output | 1 | Push `ret_addr` onto the stack |
| pop_req | output | 1 | Pop the stack (`stack_word` was used) |
| ret_addr | output | 16 | Return address to push |
| b_next | output | 8 | New B register value |
| iff_copy | output | 1 | Copy IFF2 into IFF1 |
| cycles | output | 5 | Cost in T-states |
| unsupported | output | 1 | Opcode is outside the handled set |

## Verification
A wrong state or a wrong registered result shows on the very next cycle after the instruction is accepted. A misrouted condition code or flag bit makes `taken`, `next_pc` and `cycles` diverge together. A stale hold state shows up as `res_valid` staying high one cycle after `dec_en` falls. A reference model in the bench predicts every output for every accepted instruction and compares it each cycle, so any error is caught within one clock. Directed sweeps cover every condition code against both values of its flag, every restart vector, the DJNZ wrap values, and the full byte space in both prefix states.

// File: rtl/cf_pkg.sv
package cf_pkg;
    localparam int CYC_W = 5;

    typedef enum logic [3:0] {
        K_NOP, K_JP, K_JR, K_DJNZ, K_CALL, K_RET, K_RST, K_RETI, K_RETN, K_BAD
    } cf_kind_e;

    typedef struct packed {
        logic [15:0]      next_pc;
        logic             taken;
        logic             push;
        logic             pop;
        logic [15:0]      ret_addr;
        logic [7:0]       b_next;
        logic             iff_copy;
        logic [CYC_W-1:0] cycles;
        logic             unsupported;
    } cf_result_t;

    localparam logic [CYC_W-1:0] T_NOP      = 5'd4;
    localparam logic [CYC_W-1:0] T_JP       = 5'd10;
    localparam logic [CYC_W-1:0] T_JR_YES   = 5'd12;
    localparam logic [CYC_W-1:0] T_JR_NO    = 5'd7;
    localparam logic [CYC_W-1:0] T_DJ_YES   = 5'd13;
    localparam logic [CYC_W-1:0] T_DJ_NO    = 5'd8;
    localparam logic [CYC_W-1:0] T_CALL_YES = 5'd17;
    localparam logic [CYC_W-1:0] T_CALL_NO  = 5'd10;
    localparam logic [CYC_W-1:0] T_RET      = 5'd10;
    localparam logic [CYC_W-1:0] T_RETC_YES = 5'd11;
    localparam logic [CYC_W-1:0] T_RETC_NO  = 5'd5;
    localparam logic [CYC_W-1:0] T_RST      = 5'd11;
    localparam logic [CYC_W-1:0] T_IRET     = 5'd14;
endpackage

// File: rtl/cf_cond_eval.sv
module cf_cond_eval #(
    parameter int CW        = 3,
    parameter int SIGN_BIT  = 7,
    parameter int ZERO_BIT  = 6,
    parameter int PV_BIT    = 2,
    parameter int CARRY_BIT = 0
) (
    input  logic [CW-1:0] code,
    input  logic [7:0]    flags,
    output logic          hit
);
    logic base_hit;

    always_comb begin
        unique case (code[1:0])
            2'd0: base_hit = !flags[ZERO_BIT];
            2'd1: base_hit =  flags[ZERO_BIT];
            2'd2: base_hit = !flags[CARRY_BIT];
            default: base_hit = flags[CARRY_BIT];
        endcase
    end

    generate
        if (CW >= 3) begin : g_full
            logic ext_hit;
            always_comb begin
                unique case (code[1:0])
                    2'd0: ext_hit = !flags[PV_BIT];
                    2'd1: ext_hit =  flags[PV_BIT];
                    2'd2: ext_hit = !flags[SIGN_BIT];
                    default: ext_hit = flags[SIGN_BIT];
                endcase
            end
            assign hit = code[2] ? ext_hit : base_hit;
        end else begin : g_short
            assign hit = base_hit;
        end
    endgenerate
endmodule

// File: rtl/cf_decode.sv
module cf_decode
    import cf_pkg::*;
(
    input  logic       prefix_ed,
    input  logic [7:0] opcode,
    output cf_kind_e   kind,
    output logic       is_cond
);
    always_comb begin
        kind    = K_BAD;
        is_cond = 1'b0;
        if (prefix_ed) begin
            if (opcode == 8'h4D)      kind = K_RETI;
            else if (opcode == 8'h45) kind = K_RETN;
        end else if (opcode == 8'h00) kind = K_NOP;
        else if (opcode == 8'h10)     kind = K_DJNZ;
        else if (opcode == 8'h18)     kind = K_JR;
        else if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
            kind = K_JR; is_cond = 1'b1;
        end else if (opcode == 8'hC3) kind = K_JP;
        else if (opcode == 8'hCD)     kind = K_CALL;
        else if (opcode == 8'hC9)     kind = K_RET;
        else if (opcode[7:6] == 2'b11) begin
            unique case (opcode[2:0])
                3'b010: begin kind = K_JP;   is_cond = 1'b1; end
                3'b100: begin kind = K_CALL; is_cond = 1'b1; end
                3'b000: begin kind = K_RET;  is_cond = 1'b1; end
                3'b111: kind = K_RST;
                default: kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/cf_nextpc_unit.sv
module cf_nextpc_unit
    import cf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              prefix_ed,
    input  logic [7:0]        opcode,
    input  logic [7:0]        imm_lo,
    input  logic [7:0]        imm_hi,
    input  logic [7:0]        flags,
    input  logic [7:0]        reg_b,
    input  logic [15:0]       pc_cur,
    input  logic [15:0]       stack_word,
    output logic              res_valid,
    output logic [15:0]       next_pc,
    output logic              taken,
    output logic              push_req,
    output logic              pop_req,
    output logic [15:0]       ret_addr,
    output logic [7:0]        b_next,
    output logic              iff_copy,
    output logic [CYC_W-1:0]  cycles,
    output logic              unsupported
);
    typedef enum logic {ST_IDLE, ST_HOLD} cf_state_e;

    cf_state_e  state_q;
    cf_result_t res_d, res_q;
    cf_kind_e   kind;
    logic       is_cond, hit3, hit2, ok3, ok2;

    cf_decode u_dec (
        .prefix_ed (prefix_ed),
        .opcode    (opcode),
        .kind      (kind),
        .is_cond   (is_cond)
    );

    cf_cond_eval #(.CW(3)) u_cc3 (.code(opcode[5:3]), .flags(flags), .hit(hit3));
    cf_cond_eval #(.CW(2)) u_cc2 (.code(opcode[4:3]), .flags(flags), .hit(hit2));

    assign ok3 = !is_cond || hit3;
    assign ok2 = !is_cond || hit2;

    logic [15:0] pc1, pc2, pc3, imm16, rel_tgt;
    logic [7:0]  b_dec;

    assign pc1     = pc_cur + 16'd1;
    assign pc2     = pc_cur + 16'd2;
    assign pc3     = pc_cur + 16'd3;
    assign imm16   = {imm_hi, imm_lo};
    assign rel_tgt = pc2 + {{8{imm_lo[7]}}, imm_lo};
    assign b_dec   = reg_b - 8'd1;

    always_comb begin
        res_d          = '0;
        res_d.next_pc  = pc1;
        res_d.b_next   = reg_b;
        res_d.cycles   = T_NOP;
        unique case (kind)
            K_NOP: ;
            K_JP: begin
                res_d.taken   = ok3;
                res_d.next_pc = ok3 ? imm16 : pc3;
                res_d.cycles  = T_JP;
            end
            K_JR: begin
                res_d.taken   = ok2;
                res_d.next_pc = ok2 ? rel_tgt : pc2;
                res_d.cycles  = ok2 ? T_JR_YES : T_JR_NO;
            end
            K_DJNZ: begin
                res_d.b_next  = b_dec;
                res_d.taken   = (b_dec != 8'd0);
                res_d.next_pc = (b_dec != 8'd0) ? rel_tgt : pc2;
                res_d.cycles  = (b_dec != 8'd0) ? T_DJ_YES : T_DJ_NO;
            end
            K_CALL: begin
                res_d.taken    = ok3;
                res_d.push     = ok3;
                res_d.ret_addr = pc3;
                res_d.next_pc  = ok3 ? imm16 : pc3;
                res_d.cycles   = ok3 ? T_CALL_YES : T_CALL_NO;
            end
            K_RET: begin
                res_d.taken   = ok3;
                res_d.pop     = ok3;
                res_d.next_pc = ok3 ? stack_word : pc1;
                res_d.cycles  = !is_cond ? T_RET : (ok3 ? T_RETC_YES : T_RETC_NO);
            end
            K_RST: begin
                res_d.taken    = 1'b1;
                res_d.push     = 1'b1;
                res_d.ret_addr = pc1;
                res_d.next_pc  = {10'd0, opcode[5:3], 3'd0};
                res_d.cycles   = T_RST;
            end
            K_RETI, K_RETN: begin
                res_d.taken    = 1'b1;
                res_d.pop      = 1'b1;
                res_d.next_pc  = stack_word;
                res_d.iff_copy = (kind == K_RETN);
                res_d.cycles   = T_IRET;
            end
            default: res_d.unsupported = 1'b1;
        endcase
    end

    // State register and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= dec_en ? ST_HOLD : ST_IDLE;
                ST_HOLD: state_q <= dec_en ? ST_HOLD : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
            res_q <= dec_en ? res_d : '0;
        end
    end

    // Output process
    always_comb begin
        res_valid   = (state_q == ST_HOLD);
        next_pc     = res_q.next_pc;
        taken       = res_q.taken;
        push_req    = res_q.push;
        pop_req     = res_q.pop;
        ret_addr    = res_q.ret_addr;
        b_next      = res_q.b_next;
        iff_copy    = res_q.iff_copy;
        cycles      = res_q.cycles;
        unsupported = res_q.unsupported;
    end

    p_bad_no_stack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && unsupported) |-> (!push_req && !pop_req && next_pc == $past(pc_cur) + 16'd1));

    p_pop_loads_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> (res_valid && next_pc == $past(stack_word)));

    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req));

    p_djnz_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(prefix_ed) && $past(opcode) == 8'h10) |-> (b_next == $past(reg_b) - 8'd1));

    p_rst_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(prefix_ed) && $past(opcode[7:6]) == 2'b11 && $past(opcode[2:0]) == 3'b111)
        |-> (push_req && next_pc[15:6] == 10'd0 && cycles == T_RST));

    p_iff_needs_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        iff_copy |-> pop_req);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!push_req && !pop_req && !taken && cycles == '0));
endmodule

// File: tb/cf_nextpc_unit_test.sv
`timescale 1ns/1ps
module cf_nextpc_unit_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, dec_en, prefix_ed;
    logic [7:0]  opcode, imm_lo, imm_hi, flags, reg_b;
    logic [15:0] pc_cur, stack_word;
    logic        res_valid, taken, push_req, pop_req, iff_copy, unsupported;
    logic [15:0] next_pc, ret_addr;
    logic [7:0]  b_next;
    logic [4:0]  cycles;

    cf_nextpc_unit uut (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .prefix_ed(prefix_ed),
        .opcode(opcode), .imm_lo(imm_lo), .imm_hi(imm_hi), .flags(flags),
        .reg_b(reg_b), .pc_cur(pc_cur), .stack_word(stack_word),
        .res_valid(res_valid), .next_pc(next_pc), .taken(taken),
        .push_req(push_req), .pop_req(pop_req), .ret_addr(ret_addr),
        .b_next(b_next), .iff_copy(iff_copy), .cycles(cycles),
        .unsupported(unsupported)
    );

    int n_cmp = 0, n_bad = 0;
    bit have_exp = 0;
    logic [15:0] e_pc, e_ret;
    logic        e_tk, e_push, e_pop, e_iff, e_bad;
    logic [7:0]  e_b;
    int          e_cyc;
    string       e_tag;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cond_ok(input int c, input logic [7:0] f);
        case (c)
            0: return !f[6];
            1: return f[6];
            2: return !f[0];
            3: return f[0];
            4: return !f[2];
            5: return f[2];
            6: return !f[7];
            default: return f[7];
        endcase
    endfunction

    task automatic model();
        logic [15:0] rel;
        int c3, c2;
        bit ok;
        rel = pc_cur + 16'd2 + {{8{imm_lo[7]}}, imm_lo};
        c3 = int'(opcode[5:3]);
        c2 = int'(opcode[4:3]);
        e_pc = pc_cur + 16'd1; e_tk = 0; e_push = 0; e_pop = 0; e_ret = 16'h0;
        e_b = reg_b; e_iff = 0; e_cyc = 4; e_bad = 0; e_tag = "R14";
        if (prefix_ed) begin
            if (opcode == 8'h4D || opcode == 8'h45) begin
                e_tag = "R11"; e_pop = 1; e_tk = 1; e_pc = stack_word; e_cyc = 14;
                e_iff = (opcode == 8'h45);
            end else begin
                e_tag = "R13"; e_bad = 1;
            end
        end else if (opcode == 8'h00) begin
            e_tag = "R14";
        end else if (opcode == 8'h10) begin
            e_tag = "R7"; e_b = reg_b - 8'd1;
            ok = (e_b != 0);
            e_tk = ok; e_pc = ok ? rel : pc_cur + 16'd2; e_cyc = ok ? 13 : 8;
        end else if (opcode == 8'h18) begin
            e_tag = "R6"; e_tk = 1; e_pc = rel; e_cyc = 12;
        end else if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
            e_tag = "R4 R6"; ok = cond_ok(c2, flags);
            e_tk = ok; e_pc = ok ? rel : pc_cur + 16'd2; e_cyc = ok ? 12 : 7;
        end else if (opcode == 8'hC3) begin
            e_tag = "R5"; e_tk = 1; e_pc = {imm_hi, imm_lo}; e_cyc = 10;
        end else if (opcode == 8'hCD) begin
            e_tag = "R8"; e_tk = 1; e_push = 1; e_ret = pc_cur + 16'd3;
            e_pc = {imm_hi, imm_lo}; e_cyc = 17;
        end else if (opcode == 8'hC9) begin
            e_tag = "R9"; e_tk = 1; e_pop = 1; e_pc = stack_word; e_cyc = 10;
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b010) begin
            e_tag = "R3 R5"; ok = cond_ok(c3, flags);
            e_tk = ok; e_pc = ok ? {imm_hi, imm_lo} : pc_cur + 16'd3; e_cyc = 10;
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b100) begin
            e_tag = "R3 R8"; ok = cond_ok(c3, flags);
            e_tk = ok; e_push = ok; e_ret = pc_cur + 16'd3;
            e_pc = ok ? {imm_hi, imm_lo} : pc_cur + 16'd3; e_cyc = ok ? 17 : 10;
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b000) begin
            e_tag = "R3 R9"; ok = cond_ok(c3, flags);
            e_tk = ok; e_pop = ok; e_pc = ok ? stack_word : pc_cur + 16'd1;
            e_cyc = ok ? 11 : 5;
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b111) begin
            e_tag = "R10"; e_tk = 1; e_push = 1; e_ret = pc_cur + 16'd1;
            e_pc = 16'(c3 * 8); e_cyc = 11;
        end else begin
            e_tag = "R13"; e_bad = 1;
        end
    endtask

    task automatic compare_now();
        if (have_exp) begin
            chk("R2", "res_valid", res_valid, 1);
            chk(e_tag, "next_pc", next_pc, e_pc);
            chk(e_tag, "taken", taken, e_tk);
            chk(e_tag, "push_req", push_req, e_push);
            chk(e_tag, "pop_req", pop_req, e_pop);
            if (e_push) chk(e_tag, "ret_addr", ret_addr, e_ret);
            chk("R7", "b_next", b_next, e_b);
            chk("R11", "iff_copy", iff_copy, e_iff);
            chk("R12", "cycles", cycles, e_cyc);
            chk("R13", "unsupported", unsupported, e_bad);
        end else begin
            chk("R2", "res_valid idle", res_valid, 0);
            chk("R2", "push/pop/taken idle", {push_req, pop_req, taken}, 0);
        end
    endtask

    // One cycle: check the previous result, then present new inputs.
    task automatic step(input bit en, input bit pf, input logic [7:0] op,
                        input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] fl, input logic [7:0] b,
                        input logic [15:0] pc, input logic [15:0] sw);
        @(negedge clk);
        compare_now();
        dec_en = en; prefix_ed = pf; opcode = op; imm_lo = lo; imm_hi = hi;
        flags = fl; reg_b = b; pc_cur = pc; stack_word = sw;
        if (en) model();
        have_exp = en;
    endtask

    initial begin : watchdog
        #700000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; dec_en = 1; prefix_ed = 0; opcode = 8'hC3; imm_lo = 8'h34;
        imm_hi = 8'h12; flags = 0; reg_b = 0; pc_cur = 16'h100; stack_word = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset holds everything at zero even with dec_en high
        chk("R1", "res_valid in reset", res_valid, 0);
        chk("R1", "next_pc in reset", next_pc, 0);
        chk("R1", "cycles in reset", cycles, 0);
        dec_en = 0; rst_n = 1;
        @(negedge clk);
        chk("R1", "res_valid after release", res_valid, 0);
        chk("R1", "push/pop after release", {push_req, pop_req}, 0);
        // every condition code against both flag values
        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 2; v++) begin
                logic [7:0] fl;
                fl = v ? 8'hFF : 8'h00;
                step(1, 0, {2'b11, 3'(c), 3'b010}, 8'h78, 8'h56, fl, 8'h5, 16'h4000, 16'hBEEF);
                step(1, 0, {2'b11, 3'(c), 3'b100}, 8'h78, 8'h56, fl, 8'h5, 16'hFFFE, 16'hBEEF);
                step(1, 0, {2'b11, 3'(c), 3'b000}, 8'h78, 8'h56, fl, 8'h5, 16'h4000, 16'hBEEF);
                if (c < 4)
                    step(1, 0, {3'b001, 2'(c), 3'b000}, 8'h80, 8'h0, fl, 8'h5, 16'h0010, 16'h0);
            end
        end
        // single-flag patterns to separate the flag bits (R3)
        for (int bit_i = 0; bit_i < 8; bit_i++)
            for (int c = 0; c < 8; c++)
                step(1, 0, {2'b11, 3'(c), 3'b010}, 8'h11, 8'h22, 8'(1 << bit_i), 8'h1, 16'h2000, 16'h0);
        // DJNZ boundaries (R7) and relative wrap (R6)
        step(1, 0, 8'h10, 8'hFE, 8'h0, 8'h0, 8'h01, 16'h1234, 16'h0);
        step(1, 0, 8'h10, 8'hFE, 8'h0, 8'h0, 8'h00, 16'h1234, 16'h0);
        step(1, 0, 8'h10, 8'h7F, 8'h0, 8'h0, 8'h02, 16'hFFF0, 16'h0);
        step(1, 0, 8'h18, 8'h80, 8'h0, 8'h0, 8'h02, 16'h0005, 16'h0);
        // all restart vectors (R10) and the idle gap (R2)
        for (int t = 0; t < 8; t++)
            step(1, 0, {2'b11, 3'(t), 3'b111}, 8'h0, 8'h0, 8'h0, 8'h9, 16'h8000 + 16'(t), 16'h0);
        step(0, 0, 8'hC3, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
        step(0, 0, 8'hC3, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
        // full byte space, both prefix states (R11 R13 R14)
        for (int p = 0; p < 2; p++)
            for (int o = 0; o < 256; o++)
                step(1, p[0], 8'(o), 8'(o * 7), 8'(o * 3), 8'(o), 8'(o + 1), 16'(o * 257), 16'hA5A5 ^ 16'(o));
        // random traffic with gaps
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, ($urandom % 8) == 0, 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
        step(0, 0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
        step(0, 0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule